// File: doc/BRIEF.md
# Cache Range Maintenance Splitter

This block sits between a requester and a cache controller. It takes one maintenance request: a byte start address, an exclusive byte end address, an operation (invalidate, clean or flush) and a write-through override flag. It turns that request into a series of commands the cache can execute. A command is either a single-line clean-and-invalidate or a range clean or range invalidate over an inclusive window of line addresses. The block emits one command at a time on a single command port. After each command it waits for the cache's done pulse, and it signals completion of the whole request with a one-cycle pulse.

Each range command is split into chunks. A chunk never spans more than the maximum chunk size and never crosses a page. For an invalidate, a partly covered line at either end gets a clean-and-invalidate, so that bytes outside the request are never discarded. Clean and flush widen the request out to whole lines. With write-through override set, no clean work is issued, because the cache holds no dirty data.

Top module: `rms_splitter`

## Requirements
- R1: After reset `busy`, `req_done` and `cmd_valid` are 0.
- R2: Lines are 32 bytes. For an invalidate whose start is not line-aligned, the first command is a single-line clean-and-invalidate (kind 0) at the start rounded down to a line, and invalidation then continues from the next line boundary.
- R3: For an invalidate whose end is not line-aligned and still lies above the advanced start, the next command is a single-line clean-and-invalidate at the end rounded down. Range invalidates then cover only the whole lines below that point.
- R4: A range command carries its first line address and its last line address, both inclusive. The last line address is the chunk limit minus 32, and no chunk covers more than 1024 bytes.
- R5: No range command crosses a 4096-byte page. Its limit is clipped to the next page boundary above its start.
- R6: Clean (op 1) and flush (op 2) round the start down and the end up to line boundaries. Clean issues range cleans (kind 1) chunk by chunk, in rising address order.
- R7: Flush issues, for each chunk, a range clean followed by a range invalidate (kind 2) with the same bounds.
- R8: `wt_override` is sampled when the request is accepted. When it is 1, a clean issues no command and a flush issues only the range invalidates.
- R9: A range command occupies two consecutive `cmd_valid` cycles: `cmd_beat`=0 with the start line address, then `cmd_beat`=1 with the end line address, with the same kind on both. A single-line command is one cycle with `cmd_beat`=0.
- R10: After a command's last beat, `cmd_valid` stays 0 until `cmd_done` has been seen.
- R11: `req_done` is a single-cycle pulse after the last command's done. A request that is empty after alignment gives the pulse without issuing any command, and the block then returns to idle.
- R12: `req_valid` is accepted only while the block is idle. A request presented while the block is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush, 3 no-op |
| req_start | input | AW | First byte address |
| req_end | input | AW | Byte address one past the last |
| wt_override | input | 1 | Write-through override, sampled on acceptance |
| busy | output | 1 | Request in progress |
| req_done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Command beat valid |
| cmd_kind | output | 2 | 0 line clean+invalidate, 1 range clean, 2 range invalidate |
| cmd_beat | output | 1 | 0 start address beat, 1 end address beat |
| cmd_addr | output | AW | Line address of this beat |
| cmd_done | input | 1 | Cache has finished the current command |

## Verification
The assertions assume three things about the inputs: the start does not exceed the end, neither address lies in the topmost page of the address space (so rounding up never wraps), and `cmd_done` is only pulsed while a command is outstanding. The stimulus keeps every address well below the top of the space, orders start and end in every request, and raises `cmd_done` only a few cycles after the last beat of a command.

// File: rtl/rms_pkg.sv
package rms_pkg;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        K_LINE   = 2'd0,
        K_RCLEAN = 2'd1,
        K_RINV   = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PLAN  = 3'd1,
        S_EMIT0 = 3'd2,
        S_EMIT1 = 3'd3,
        S_WAIT  = 3'd4,
        S_DONE  = 3'd5
    } state_e;

    function automatic logic two_beats(kind_e k);
        return k != K_LINE;
    endfunction

endpackage

// File: rtl/rms_align.sv
module rms_align
    import rms_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  op_e           op,
    input  logic [AW-1:0] start_b,
    input  logic [AW-1:0] end_b,
    input  logic          wt,
    output logic          head_vld,
    output logic [AW-1:0] head_addr,
    output logic          tail_vld,
    output logic [AW-1:0] tail_addr,
    output logic [AW-1:0] run_s,
    output logic [AW-1:0] run_e
);
    localparam logic [AW-1:0] LMASK = AW'(LINE_BYTES - 1);
    localparam logic [AW-1:0] LSTEP = AW'(LINE_BYTES);

    logic [AW-1:0] s_dn, e_dn, e_up, s_adv;
    logic          s_off, e_off;

    always_comb begin
        s_dn  = start_b & ~LMASK;
        e_dn  = end_b & ~LMASK;
        e_up  = (end_b + LMASK) & ~LMASK;
        s_off = |(start_b & LMASK);
        e_off = |(end_b & LMASK);
        s_adv = s_off ? s_dn + LSTEP : start_b;

        head_vld  = 1'b0;
        tail_vld  = 1'b0;
        head_addr = s_dn;
        tail_addr = e_dn;
        run_s     = s_dn;
        run_e     = s_dn;
        unique case (op)
            OP_INV: begin
                head_vld = s_off;
                tail_vld = (s_adv < end_b) && e_off;
                run_s    = s_adv;
                run_e    = tail_vld ? e_dn : end_b;
            end
            OP_CLEAN: begin
                run_e = wt ? s_dn : e_up;
            end
            OP_FLUSH: begin
                run_e = e_up;
            end
            default: begin
                run_e = s_dn;
            end
        endcase
    end
endmodule

// File: rtl/rms_chunk.sv
module rms_chunk #(
    parameter int AW         = 32,
    parameter int MAX_CHUNK  = 1024,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [AW-1:0] cur_s,
    input  logic [AW-1:0] cur_e,
    output logic [AW-1:0] limit
);
    localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

    logic [AW-1:0] cap, pg_top, lim0;

    always_comb begin
        cap    = cur_s + AW'(MAX_CHUNK);
        pg_top = (cur_s | PMASK) + AW'(1);
        lim0   = (cur_e > cap) ? cap : cur_e;
        limit  = (lim0 > pg_top) ? pg_top : lim0;
    end
endmodule

// File: rtl/rms_seq.sv
module rms_seq
    import rms_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int MAX_CHUNK  = 1024,
    parameter int PAGE_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  op_e           req_op,
    input  logic          wt,
    input  logic          pre_head,
    input  logic [AW-1:0] pre_head_a,
    input  logic          pre_tail,
    input  logic [AW-1:0] pre_tail_a,
    input  logic [AW-1:0] pre_s,
    input  logic [AW-1:0] pre_e,
    input  logic          cmd_done,
    output logic          busy,
    output logic          req_done,
    output logic          cmd_valid,
    output kind_e         cmd_kind,
    output logic          cmd_beat,
    output logic [AW-1:0] cmd_addr
);
    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);

    state_e        state;
    op_e           op_q;
    logic          wt_q, head_q, tail_q, second_q;
    logic [AW-1:0] head_a, tail_a, s_q, e_q, a_q, b_q;
    kind_e         kind_q;
    logic [AW-1:0] lim;
    logic          do_clean;

    rms_chunk #(.AW(AW), .MAX_CHUNK(MAX_CHUNK), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .cur_s (s_q),
        .cur_e (e_q),
        .limit (lim)
    );

    assign do_clean = (op_q == OP_CLEAN) ||
                      (op_q == OP_FLUSH && !wt_q && !second_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            op_q     <= OP_NONE;
            wt_q     <= 1'b0;
            head_q   <= 1'b0;
            tail_q   <= 1'b0;
            second_q <= 1'b0;
            head_a   <= '0;
            tail_a   <= '0;
            s_q      <= '0;
            e_q      <= '0;
            a_q      <= '0;
            b_q      <= '0;
            kind_q   <= K_LINE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q     <= req_op;
                    wt_q     <= wt;
                    head_q   <= pre_head;
                    head_a   <= pre_head_a;
                    tail_q   <= pre_tail;
                    tail_a   <= pre_tail_a;
                    s_q      <= pre_s;
                    e_q      <= pre_e;
                    second_q <= 1'b0;
                    state    <= S_PLAN;
                end
                S_PLAN: begin
                    if (head_q) begin
                        head_q <= 1'b0;
                        kind_q <= K_LINE;
                        a_q    <= head_a;
                        b_q    <= head_a;
                        state  <= S_EMIT0;
                    end else if (tail_q) begin
                        tail_q <= 1'b0;
                        kind_q <= K_LINE;
                        a_q    <= tail_a;
                        b_q    <= tail_a;
                        state  <= S_EMIT0;
                    end else if (s_q < e_q) begin
                        a_q <= s_q;
                        b_q <= lim - AW'(LINE_BYTES);
                        if (do_clean) begin
                            kind_q <= K_RCLEAN;
                            if (op_q == OP_FLUSH) second_q <= 1'b1;
                            else                  s_q      <= lim;
                        end else begin
                            kind_q   <= K_RINV;
                            s_q      <= lim;
                            second_q <= 1'b0;
                        end
                        state <= S_EMIT0;
                    end else begin
                        state <= S_DONE;
                    end
                end
                S_EMIT0: state <= two_beats(kind_q) ? S_EMIT1 : S_WAIT;
                S_EMIT1: state <= S_WAIT;
                S_WAIT:  if (cmd_done) state <= S_PLAN;
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign req_done  = (state == S_DONE);
    assign cmd_valid = (state == S_EMIT0) || (state == S_EMIT1);
    assign cmd_beat  = (state == S_EMIT1);
    assign cmd_kind  = kind_q;
    assign cmd_addr  = (state == S_EMIT1) ? b_q : a_q;

    // R9: a range start beat is followed at once by its end beat of the same kind
    a_r9_end_follows: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_beat && cmd_kind != K_LINE) |=>
        (cmd_valid && cmd_beat && $stable(cmd_kind)));

    // R9: single-line commands never carry an end beat
    a_r9_line_one_beat: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == K_LINE) |-> !cmd_beat);

    // R2: every emitted address is line aligned
    a_r2_line_aligned: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_addr[LINE_SH-1:0] == '0));

    // R4: end line not below start line and span within the chunk cap
    a_r4_chunk_cap: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_beat) |->
        (cmd_addr >= $past(cmd_addr) &&
         (cmd_addr - $past(cmd_addr)) <= AW'(MAX_CHUNK - LINE_BYTES)));

    // R5: start and end beat lie in the same page
    a_r5_same_page: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_beat) |->
        ((cmd_addr >> PAGE_SH) == ($past(cmd_addr) >> PAGE_SH)));

    // R8: no range clean under write-through override
    a_r8_wt_no_clean: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && wt_q) |-> (cmd_kind != K_RCLEAN));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        req_done |=> !req_done);

    // R10: no beat in the cycle right after the wait ends without a plan step
    a_r10_wait_then_plan: assert property (@(posedge clk) disable iff (rst)
        (busy && !cmd_valid && !req_done && $past(cmd_valid)) |=> !cmd_valid);
endmodule

// File: rtl/rms_splitter.sv
module rms_splitter
    import rms_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32,
    parameter int MAX_CHUNK  = 1024,
    parameter int PAGE_BYTES = 4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_end,
    input  logic          wt_override,
    output logic          busy,
    output logic          req_done,
    output logic          cmd_valid,
    output logic [1:0]    cmd_kind,
    output logic          cmd_beat,
    output logic [AW-1:0] cmd_addr,
    input  logic          cmd_done
);
    op_e           op_in;
    kind_e         kind_out;
    logic          p_head, p_tail;
    logic [AW-1:0] p_head_a, p_tail_a, p_s, p_e;

    assign op_in    = op_e'(req_op);
    assign cmd_kind = kind_out;

    rms_align #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_align (
        .op        (op_in),
        .start_b   (req_start),
        .end_b     (req_end),
        .wt        (wt_override),
        .head_vld  (p_head),
        .head_addr (p_head_a),
        .tail_vld  (p_tail),
        .tail_addr (p_tail_a),
        .run_s     (p_s),
        .run_e     (p_e)
    );

    rms_seq #(
        .AW(AW), .LINE_BYTES(LINE_BYTES),
        .MAX_CHUNK(MAX_CHUNK), .PAGE_BYTES(PAGE_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (op_in),
        .wt         (wt_override),
        .pre_head   (p_head),
        .pre_head_a (p_head_a),
        .pre_tail   (p_tail),
        .pre_tail_a (p_tail_a),
        .pre_s      (p_s),
        .pre_e      (p_e),
        .cmd_done   (cmd_done),
        .busy       (busy),
        .req_done   (req_done),
        .cmd_valid  (cmd_valid),
        .cmd_kind   (kind_out),
        .cmd_beat   (cmd_beat),
        .cmd_addr   (cmd_addr)
    );

    // R12: accepting work only from idle
    a_r12_idle_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && !req_valid) |=> !busy);
endmodule

// File: tb/tb_rms_splitter.sv
module tb_rms_splitter;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    // {op, wt, start, end, expected command count}
    localparam logic [74:0] VECS [NV] = '{
        {2'd0, 1'b0, 32'h0000_1000, 32'h0000_1400, 8'd1},
        {2'd0, 1'b0, 32'h0000_1004, 32'h0000_1044, 8'd3},
        {2'd0, 1'b0, 32'h0000_1004, 32'h0000_1010, 8'd1},
        {2'd0, 1'b0, 32'h0000_0F00, 32'h0000_1100, 8'd2},
        {2'd0, 1'b0, 32'h0000_2000, 32'h0000_2900, 8'd3},
        {2'd1, 1'b0, 32'h0000_3010, 32'h0000_3050, 8'd1},
        {2'd1, 1'b1, 32'h0000_3010, 32'h0000_3050, 8'd0},
        {2'd2, 1'b0, 32'h0000_3FF0, 32'h0000_4010, 8'd4},
        {2'd2, 1'b1, 32'h0000_3FF0, 32'h0000_4010, 8'd2},
        {2'd0, 1'b0, 32'h0000_5000, 32'h0000_5000, 8'd0},
        {2'd1, 1'b0, 32'h0000_5020, 32'h0000_5020, 8'd0},
        {2'd0, 1'b0, 32'h0000_6000, 32'h0000_7400, 8'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [31:0] req_start = '0, req_end = '0;
    logic        wt_override = 1'b0;
    logic        cmd_done = 1'b0;
    logic        busy, req_done, cmd_valid, cmd_beat;
    logic [1:0]  cmd_kind;
    logic [31:0] cmd_addr;

    int n_tests = 0;
    int n_fail  = 0;

    logic [1:0]  exp_k [16];
    logic [31:0] exp_a [16], exp_b [16];
    int          n_exp;
    logic [1:0]  got_k [16];
    logic [31:0] got_a [16], got_b [16];
    int          n_got;
    string       tags [NV];

    always #(CLK_PERIOD/2) clk = ~clk;

    rms_splitter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_start(req_start), .req_end(req_end), .wt_override(wt_override),
        .busy(busy), .req_done(req_done), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .cmd_beat(cmd_beat), .cmd_addr(cmd_addr),
        .cmd_done(cmd_done)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic [1:0] k, input logic [31:0] a, input logic [31:0] b);
        if (n_exp < 16) begin
            exp_k[n_exp] = k; exp_a[n_exp] = a; exp_b[n_exp] = b;
        end
        n_exp++;
    endtask

    function automatic logic [31:0] chunk_end(input logic [31:0] s, input logic [31:0] e);
        logic [31:0] lim, pg;
        lim = e;
        if (lim > s + 1024) lim = s + 1024;
        pg = ((s / 4096) + 1) * 4096;
        if (lim > pg) lim = pg;
        return lim;
    endfunction

    task automatic build_exp(input logic [1:0] op, input logic [31:0] si,
                             input logic [31:0] ei, input logic wt);
        logic [31:0] s, e, lim;
        n_exp = 0;
        s = si; e = ei;
        if (op == 2'd0) begin
            if (s % 32 != 0) begin
                push_exp(2'd0, s - (s % 32), s - (s % 32));
                s = s - (s % 32) + 32;
            end
            if (s < e && e % 32 != 0) begin
                push_exp(2'd0, e - (e % 32), e - (e % 32));
                e = e - (e % 32);
            end
            while (s < e) begin
                lim = chunk_end(s, e);
                push_exp(2'd2, s, lim - 32);
                s = lim;
            end
        end else if (op == 2'd1 || op == 2'd2) begin
            s = s - (s % 32);
            e = ((e + 31) / 32) * 32;
            while (s < e) begin
                lim = chunk_end(s, e);
                if (!wt) push_exp(2'd1, s, lim - 32);
                if (op == 2'd2) push_exp(2'd2, s, lim - 32);
                s = lim;
            end
        end
    endtask

    task automatic run_req(input logic [1:0] op, input logic [31:0] s, input logic [31:0] e,
                           input logic wt, input bit junk);
        int guard;
        bit done_seen;
        logic [1:0]  k;
        logic [31:0] a, b;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_start = s; req_end = e; wt_override = wt;
        @(negedge clk);
        if (junk) begin
            req_op = 2'd2; req_start = 32'h9000; req_end = 32'h9400; wt_override = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        n_got = 0; guard = 0; done_seen = 1'b0;
        while (!done_seen && guard < 3000) begin
            if (req_done) begin
                done_seen = 1'b1;
            end else if (cmd_valid) begin
                chk(cmd_beat == 1'b0, "R9", "first beat flag", 32'(cmd_beat), 32'd0);
                k = cmd_kind; a = cmd_addr; b = a;
                if (k != 2'd0) begin
                    @(negedge clk); guard++;
                    chk(cmd_valid && cmd_beat && cmd_kind == k, "R9", "end beat follows",
                        {30'd0, cmd_valid, cmd_beat}, 32'd3);
                    b = cmd_addr;
                end
                if (n_got < 16) begin
                    got_k[n_got] = k; got_a[n_got] = a; got_b[n_got] = b;
                end
                n_got++;
                repeat (3) begin
                    @(negedge clk); guard++;
                    chk(!cmd_valid, "R10", "idle until done", 32'(cmd_valid), 32'd0);
                end
                cmd_done = 1'b1;
                @(negedge clk); guard++;
                cmd_done = 1'b0;
            end else begin
                @(negedge clk); guard++;
            end
        end
        req_valid = 1'b0;
        chk(done_seen, "R11", "completion seen", 32'(done_seen), 32'd1);
        @(negedge clk);
        chk(!req_done && !busy, "R11", "pulse ends, idle", {30'd0, req_done, busy}, 32'd0);
    endtask

    task automatic compare(input string rq);
        chk(n_got == n_exp, rq, "command count vs model", 32'(n_got), 32'(n_exp));
        for (int i = 0; i < n_got && i < n_exp && i < 16; i++) begin
            chk(got_k[i] == exp_k[i], rq, "command kind", 32'(got_k[i]), 32'(exp_k[i]));
            chk(got_a[i] == exp_a[i], rq, "start line", got_a[i], exp_a[i]);
            chk(got_b[i] == exp_b[i], rq, "end line", got_b[i], exp_b[i]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        tags = '{"R4", "R3", "R2", "R5", "R4", "R6", "R8", "R7", "R8", "R11", "R11", "R5"};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !req_done && !cmd_valid, "R1", "reset outputs",
            {29'd0, busy, req_done, cmd_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !cmd_valid, "R1", "idle after reset", {30'd0, busy, cmd_valid}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            build_exp(VECS[v][74:73], VECS[v][71:40], VECS[v][39:8], VECS[v][72]);
            run_req(VECS[v][74:73], VECS[v][71:40], VECS[v][39:8], VECS[v][72], 1'b0);
            chk(n_got == int'(VECS[v][7:0]), tags[v], "command count vs table",
                32'(n_got), 32'(VECS[v][7:0]));
            compare(tags[v]);
        end

        // R12: a different request held on the inputs while busy changes nothing
        build_exp(2'd0, 32'h0000_1004, 32'h0000_1044, 1'b0);
        run_req(2'd0, 32'h0000_1004, 32'h0000_1044, 1'b0, 1'b1);
        compare("R12");
        @(negedge clk);
        chk(!busy && !cmd_valid, "R12", "no stray request accepted",
            {30'd0, busy, cmd_valid}, 32'd0);

        // R8: override flips per request and is sampled at acceptance
        build_exp(2'd2, 32'h0000_8000, 32'h0000_8040, 1'b0);
        run_req(2'd2, 32'h0000_8000, 32'h0000_8040, 1'b0, 1'b0);
        compare("R8");

        // R7: flush spanning several chunks, clean then invalidate per chunk
        build_exp(2'd2, 32'h0000_A3F0, 32'h0000_AC10, 1'b0);
        run_req(2'd2, 32'h0000_A3F0, 32'h0000_AC10, 1'b0, 1'b0);
        compare("R7");

        // R11: reserved opcode completes with no commands
        run_req(2'd3, 32'h0000_B000, 32'h0000_B100, 1'b0, 1'b0);
        chk(n_got == 0, "R11", "no-op request commands", 32'(n_got), 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule